// File: doc/BRIEF.md
# Block Move and Search Engine

This block steps through memory one byte at a time on behalf of a processor core. Once it is started it runs one of four operations. Copy moves a byte from the source pointer to the destination pointer. Search compares the byte at the source pointer with an accumulator value. Port-in reads a byte from an I/O port and stores it at the pointer. Port-out reads a byte at the pointer and sends it to an I/O port. Each step moves the pointers up or down by one and decrements a counter. The operation either stops after one step or repeats until the operation's own stop condition is met.

The core loads the three working register pairs, the accumulator and the current flags on a start strobe. It then waits for a one-cycle done pulse and reads back the updated register values and flags. Memory and I/O are reached through two request/acknowledge ports. A request and its address stay steady until the matching acknowledge arrives.

Top module: `blkxfer_engine`

## Requirements
- R1: After reset, busy, done, mem_req and io_req are all 0.
- R2: Copy (op=0) reads the byte at src, writes it at dst, and moves both pointers by +1 (dir_dec=0) or -1 (dir_dec=1). Each byte decrements cnt by one. In repeat mode the copy continues until cnt reaches zero.
- R3: With repeat_en=0, every operation performs exactly one step per start, whatever the count.
- R4: Flag bits are S=7, Z=6, H=4, PV=2, N=1, C=0. After copy or search, PV is 0 if the 16-bit count ended at zero and 1 otherwise. Copy forces H and N to 0 and passes bits 7, 6, 5, 3 and 0 through unchanged.
- R5: Search (op=1) compares acc with the byte at src and moves only src. It makes no memory write and leaves dst unchanged. It sets N=1, and sets Z=1 exactly when the last compared byte equals acc.
- R6: A repeating search stops on the first match or when cnt reaches zero. It leaves src one past the matched byte when incrementing, or one before it when decrementing.
- R7: Port-in (op=2) reads port cnt[7:0] and writes the byte at src. Port-out (op=3) reads the byte at src and writes it to port cnt[7:0]. These I/O operations count in cnt[15:8] only, and cnt[7:0] and dst stay unchanged. At the end Z shows whether cnt[15:8] is zero, N=1, and all other flags pass through.
- R8: A count of zero at start means 65536 steps for copy and search, and a high byte of zero means 256 steps for I/O, because the count is decremented before it is tested.
- R9: A memory or I/O request holds its address steady until it is acknowledged. done is a pulse of one cycle in the cycle when the final register values appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch strobe, honoured while idle |
| op | input | 2 | 0 copy, 1 search, 2 port-in, 3 port-out |
| dir_dec | input | 1 | 1 decrements pointers, 0 increments |
| repeat_en | input | 1 | 1 repeats until termination |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial destination pointer |
| cnt_in | input | 16 | Initial count (I/O: high byte count, low byte port) |
| acc_in | input | 8 | Search comparand |
| flags_in | input | 8 | Flags before the operation |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when 1 |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Memory read data, valid with ack |
| io_req | output | 1 | I/O request |
| io_we | output | 1 | I/O write when 1 |
| io_port | output | 8 | I/O port number |
| io_wdata | output | 8 | I/O write data |
| io_ack | input | 1 | I/O acknowledge |
| io_rdata | input | 8 | I/O read data, valid with ack |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Termination pulse |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current count |
| flags_out | output | 8 | Current flags |

## Verification
In a repeating search, a match and the exhaustion of the count can happen on the same step. The bench causes this by placing the only matching byte at the last position of a three-byte search. It then expects a single done pulse with Z=1 and PV=0, the count at zero, and the source pointer one past the match. Separate cases that match early or never match show that each stop condition works on its own.

// File: rtl/blkxfer_engine.sv
module blkxfer_engine #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          dir_dec,
  input  logic          repeat_en,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [15:0]   cnt_in,
  input  logic [DW-1:0] acc_in,
  input  logic [7:0]    flags_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          io_req,
  output logic          io_we,
  output logic [7:0]    io_port,
  output logic [DW-1:0] io_wdata,
  input  logic          io_ack,
  input  logic [DW-1:0] io_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_out,
  output logic [AW-1:0] dst_out,
  output logic [15:0]   cnt_out,
  output logic [7:0]    flags_out
);
  localparam logic [1:0] OP_COPY = 2'd0, OP_FIND = 2'd1, OP_PIN = 2'd2, OP_POUT = 2'd3;
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t st;
  logic [1:0]    op_r;
  logic          dec_r, rep_r;
  logic [AW-1:0] src_r, dst_r;
  logic [15:0]   cnt_r;
  logic [DW-1:0] acc_r, dat_r;
  logic [7:0]    flg_r;

  wire is_io = op_r[1];
  wire rd_mem = (st == S_RD) && (op_r != OP_PIN);
  wire wr_mem = (st == S_WR) && (op_r != OP_POUT);
  wire rd_io  = (st == S_RD) && (op_r == OP_PIN);
  wire wr_io  = (st == S_WR) && (op_r == OP_POUT);

  assign mem_req   = rd_mem || wr_mem;
  assign mem_we    = wr_mem;
  assign mem_addr  = (wr_mem && op_r == OP_COPY) ? dst_r : src_r;
  assign mem_wdata = dat_r;
  assign io_req    = rd_io || wr_io;
  assign io_we     = wr_io;
  assign io_port   = cnt_r[7:0];
  assign io_wdata  = dat_r;
  assign busy      = (st != S_IDLE);
  assign src_out   = src_r;
  assign dst_out   = dst_r;
  assign cnt_out   = cnt_r;
  assign flags_out = flg_r;

  wire ack_now = (mem_req && mem_ack) || (io_req && io_ack);
  wire step_end = ack_now && ((st == S_WR) || (op_r == OP_FIND));

  wire [15:0]   cnt_nx  = is_io ? {cnt_r[15:8] - 8'd1, cnt_r[7:0]} : cnt_r - 16'd1;
  wire          cnt_z   = is_io ? (cnt_nx[15:8] == 8'd0) : (cnt_nx == 16'd0);
  wire [AW-1:0] src_nx  = dec_r ? src_r - 1'b1 : src_r + 1'b1;
  wire [AW-1:0] dst_nx  = dec_r ? dst_r - 1'b1 : dst_r + 1'b1;
  wire [DW-1:0] diff    = acc_r - mem_rdata;
  wire          match   = (diff == '0);
  wire          hborrow = (acc_r[3:0] < mem_rdata[3:0]);
  wire          stop    = !rep_r || cnt_z || ((op_r == OP_FIND) && match);

  logic [7:0] flg_nx;
  always_comb begin
    case (op_r)
      OP_COPY: flg_nx = {flg_r[7:5], 1'b0, flg_r[3], !cnt_z, 1'b0, flg_r[0]};
      OP_FIND: flg_nx = {diff[DW-1], match, flg_r[5], hborrow, flg_r[3], !cnt_z, 1'b1, flg_r[0]};
      default: flg_nx = {flg_r[7], cnt_z, flg_r[5:2], 1'b1, flg_r[0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_r <= OP_COPY; dec_r <= 1'b0; rep_r <= 1'b0;
      src_r <= '0; dst_r <= '0; cnt_r <= '0; acc_r <= '0; dat_r <= '0;
      flg_r <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_RD; op_r <= op; dec_r <= dir_dec; rep_r <= repeat_en;
          src_r <= src_in; dst_r <= dst_in; cnt_r <= cnt_in;
          acc_r <= acc_in; flg_r <= flags_in;
        end
        S_RD: if (ack_now && op_r != OP_FIND) begin
          dat_r <= (op_r == OP_PIN) ? io_rdata : mem_rdata;
          st <= S_WR;
        end
        default: ;
      endcase
      if (step_end) begin
        src_r <= src_nx;
        if (op_r == OP_COPY) dst_r <= dst_nx;
        cnt_r <= cnt_nx;
        flg_r <= flg_nx;
        st <= stop ? S_IDLE : S_RD;
        done <= stop;
      end
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R9
  io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !io_ack |=> io_req && $stable(io_port) && $stable(io_we));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R4
  pv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !op_r[1] |-> flags_out[2] == (cnt_out != 16'd0));
  // R4
  copy_hn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_r == OP_COPY |-> !flags_out[4] && !flags_out[1]);
  // R5
  find_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_r == OP_FIND |-> !mem_we && !io_req);
  // R6
  find_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_r == OP_FIND && rep_r |-> flags_out[6] || cnt_out == 16'd0);
  // R7
  io_port_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_r[1] |=> $stable(cnt_out[7:0]) && $stable(dst_out));
endmodule

// File: tb/sim_blkxfer_engine.sv
`timescale 1ns/1ps
module sim_blkxfer_engine;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic start = 0, dir_dec = 0, repeat_en = 0;
  logic [1:0] op = 0;
  logic [15:0] src_in = 0, dst_in = 0, cnt_in = 0;
  logic [7:0] acc_in = 0, flags_in = 0;
  logic mem_req, mem_we, mem_ack, io_req, io_we, io_ack, busy, done;
  logic [15:0] mem_addr, src_out, dst_out, cnt_out;
  logic [7:0] mem_wdata, mem_rdata, io_port, io_wdata, io_rdata, flags_out;

  blkxfer_engine u0 (.clk, .rst_n, .start, .op, .dir_dec, .repeat_en,
    .src_in, .dst_in, .cnt_in, .acc_in, .flags_in,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata,
    .io_req, .io_we, .io_port, .io_wdata, .io_ack, .io_rdata,
    .busy, .done, .src_out, .dst_out, .cnt_out, .flags_out);

  logic [7:0] mem [0:4095];
  int mem_writes = 0, io_writes = 0;
  logic [7:0] io_next = 0, last_port = 0;
  logic [7:0] io_log [0:3];
  initial begin mem_ack = 0; io_ack = 0; mem_rdata = 0; io_rdata = 0; end

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin mem[mem_addr[11:0]] <= mem_wdata; mem_writes <= mem_writes + 1; end
      else mem_rdata <= mem[mem_addr[11:0]];
    end
    io_ack <= 1'b0;
    if (io_req && !io_ack) begin
      io_ack <= 1'b1;
      last_port <= io_port;
      if (io_we) begin
        if (io_writes < 4) io_log[io_writes] <= io_wdata;
        io_writes <= io_writes + 1;
      end else begin
        io_rdata <= io_next; io_next <= io_next + 8'd1;
      end
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [1:0] o, input logic d, input logic r,
                        input logic [15:0] s, input logic [15:0] ds,
                        input logic [15:0] c, input logic [7:0] a, input logic [7:0] f);
    int n;
    @(negedge clk);
    op = o; dir_dec = d; repeat_en = r; src_in = s; dst_in = ds;
    cnt_in = c; acc_in = a; flags_in = f; start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk("R9", "watchdog done", 0, 1);
  endtask

  task automatic t_reset;
    chk("R1", "busy", busy, 0); chk("R1", "done", done, 0);
    chk("R1", "mem_req", mem_req, 0); chk("R1", "io_req", io_req, 0);
  endtask

  task automatic t_copy_inc;
    for (int i = 0; i < 5; i++) mem[12'h100 + i] = 8'h30 + 8'(i);
    mem_writes = 0;
    launch(0, 0, 1, 16'h0100, 16'h0200, 16'd5, 8'h00, 8'hFF);
    for (int i = 0; i < 5; i++) chk("R2", "copy inc data", mem[12'h200 + i], 8'h30 + i);
    chk("R2", "src", src_out, 16'h0105); chk("R2", "dst", dst_out, 16'h0205);
    chk("R2", "cnt", cnt_out, 0); chk("R2", "writes", mem_writes, 5);
    chk("R4", "copy flags", flags_out, 8'hE9);
    @(negedge clk); chk("R9", "done one cycle", done, 0);
  endtask

  task automatic t_copy_dec;
    for (int i = 0; i < 3; i++) mem[12'h302 + i] = 8'h50 + 8'(i);
    launch(0, 1, 1, 16'h0304, 16'h0404, 16'd3, 8'h00, 8'h00);
    for (int i = 0; i < 3; i++) chk("R2", "copy dec data", mem[12'h402 + i], 8'h50 + i);
    chk("R2", "src dec", src_out, 16'h0301); chk("R2", "dst dec", dst_out, 16'h0401);
    chk("R4", "pv zero", flags_out, 8'h00);
  endtask

  task automatic t_copy_single;
    mem[12'h500] = 8'h77; mem[12'h501] = 8'h78; mem[12'h581] = 8'h00;
    launch(0, 0, 0, 16'h0500, 16'h0580, 16'd2, 8'h00, 8'h12);
    chk("R3", "single data", mem[12'h580], 8'h77); chk("R3", "no 2nd byte", mem[12'h581], 8'h00);
    chk("R3", "cnt", cnt_out, 16'd1); chk("R4", "pv set", flags_out, 8'h04);
    launch(0, 0, 0, 16'h0501, 16'h0590, 16'd0, 8'h00, 8'h00);
    chk("R8", "zero count wraps", cnt_out, 16'hFFFF); chk("R8", "pv after wrap", flags_out[2], 1);
    chk("R8", "byte moved", mem[12'h590], 8'h78);
  endtask

  task automatic t_find;
    for (int i = 0; i < 5; i++) mem[12'h600 + i] = 8'h10 + 8'(i);
    mem_writes = 0;
    launch(1, 0, 1, 16'h0600, 16'h0ABC, 16'd5, 8'h12, 8'h00);
    chk("R6", "match src", src_out, 16'h0603); chk("R6", "match cnt", cnt_out, 16'd2);
    chk("R5", "Z match", flags_out[6], 1); chk("R5", "N", flags_out[1], 1);
    chk("R4", "pv", flags_out[2], 1); chk("R5", "dst kept", dst_out, 16'h0ABC);
    chk("R5", "no writes", mem_writes, 0);
    launch(1, 0, 1, 16'h0600, 16'h0000, 16'd4, 8'h99, 8'h40);
    chk("R6", "nomatch src", src_out, 16'h0604); chk("R5", "Z clear", flags_out[6], 0);
    chk("R4", "pv clear", flags_out[2], 0);
    launch(1, 1, 1, 16'h0604, 16'h0000, 16'd5, 8'h12, 8'h00);
    chk("R6", "dec match src", src_out, 16'h0601); chk("R6", "dec cnt", cnt_out, 16'd2);
    launch(1, 0, 1, 16'h0600, 16'h0000, 16'd3, 8'h12, 8'h00);
    chk("R6", "both Z", flags_out[6], 1); chk("R6", "both pv", flags_out[2], 0);
    chk("R6", "both cnt", cnt_out, 0); chk("R6", "both src", src_out, 16'h0603);
    launch(1, 0, 0, 16'h0600, 16'h0000, 16'd5, 8'h12, 8'h00);
    chk("R3", "single find src", src_out, 16'h0601); chk("R3", "single find cnt", cnt_out, 16'd4);
  endtask

  task automatic t_io;
    io_next = 8'h70;
    launch(2, 0, 1, 16'h0800, 16'h1234, 16'h035A, 8'h00, 8'h00);
    for (int i = 0; i < 3; i++) chk("R7", "pin data", mem[12'h800 + i], 8'h70 + i);
    chk("R7", "port", last_port, 8'h5A); chk("R7", "cnt", cnt_out, 16'h005A);
    chk("R7", "src", src_out, 16'h0803); chk("R7", "dst kept", dst_out, 16'h1234);
    chk("R7", "flags", flags_out, 8'h42);
    mem[12'h900] = 8'hA0; mem[12'h901] = 8'hA1; io_writes = 0;
    launch(3, 1, 1, 16'h0901, 16'h0000, 16'h0233, 8'h00, 8'h81);
    chk("R7", "pout n", io_writes, 2); chk("R7", "pout 1st", io_log[0], 8'hA1);
    chk("R7", "pout 2nd", io_log[1], 8'hA0); chk("R7", "pout src", src_out, 16'h08FF);
    chk("R7", "pout flags", flags_out, 8'hC3);
    io_writes = 0;
    launch(3, 0, 1, 16'h0A00, 16'h0000, 16'h0033, 8'h00, 8'h00);
    chk("R8", "256 writes", io_writes, 256); chk("R8", "src", src_out, 16'h0B00);
    chk("R8", "cnt", cnt_out, 16'h0033);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_copy_inc(); t_copy_dec(); t_copy_single(); t_find(); t_io();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL R9 global watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule